// File: doc/BRIEF.md
# Exclusive Access Monitor

This block guards load-exclusive / store-exclusive pairs issued by one core. It keeps a single reservation flag with no address tag. An exclusive load reads a word and arms the flag. A later exclusive store writes memory only while the flag is armed, and it reports to the requester whether the write took place. Every exclusive store disarms the flag, whether it wrote or not.

A clear input, raised on interrupt entry, also disarms the flag. A load-modify-store sequence that an interrupt breaks therefore fails, and software retries it. A small word-addressed memory model sits behind the monitor, so the read and write paths of the sequence can be observed at the ports.

Top module: `excl_gate`

## Requirements
- R1: After reset the flag is disarmed, `rsp_valid_o` is low, and an exclusive store issued first reports status 1.
- R2: An exclusive load (op code 2) returns the addressed word on `rsp_rdata_o` and arms the flag.
- R3: An exclusive store (op code 3) issued while the flag is armed writes `req_wdata_i` to the addressed word and reports status 0.
- R4: An exclusive store issued while the flag is disarmed leaves memory unchanged and reports status 1.
- R5: Every exclusive store leaves the flag disarmed, so a second exclusive store that follows directly reports status 1.
- R6: `clear_i` disarms the flag. When it arrives in the same cycle as an exclusive load, the clear wins.
- R7: When `clear_i` arrives in the same cycle as an exclusive store, the store fails with status 1 and does not write.
- R8: A plain load (op code 0) and a plain store (op code 1) leave the flag unchanged. A plain store always writes and reports status 0.
- R9: `rsp_valid_o` is high for exactly the one cycle after each accepted request and is low otherwise. Status and read data are valid in that cycle.
- R10: In an atomic-increment retry loop with injected clears, the final counter value equals the number of exclusive stores that reported status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one request per cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 exclusive load, 3 exclusive store |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| clear_i | input | 1 | Interrupt-entry clear of the flag |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | DW | Read data for loads |
| rsp_status_o | output | 1 | 0 written, 1 exclusive store refused |

## Verification
Two events can land in the same cycle: the interrupt clear together with an exclusive load, and the clear together with an exclusive store. The bench drives `clear_i` in the very cycle of the request. It then judges the load case by the status of the next exclusive store, which must be 1. It judges the store case by the returned status and by reading the target word back, which must hold its old value. The retry loop injects clears in this same cycle and also between the load and the store.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_LDX = 2'd2,
    OP_STX = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_flag.sv
module excl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic drop_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_o <= 1'b0;
    else if (drop_i) armed_o <= 1'b0;
    else if (arm_i)  armed_o <= 1'b1;
  end
endmodule

// File: rtl/excl_store_gate.sv
module excl_store_gate
  import excl_pkg::*;
(
  input  logic     req_valid_i,
  input  excl_op_e req_op_i,
  input  logic     armed_i,
  input  logic     clear_i,
  output logic     mem_we_o,
  output logic     status_o,
  output logic     arm_o,
  output logic     drop_o
);
  logic is_stx, is_ldx, is_st;

  assign is_stx = req_valid_i && (req_op_i == OP_STX);
  assign is_ldx = req_valid_i && (req_op_i == OP_LDX);
  assign is_st  = req_valid_i && (req_op_i == OP_ST);

  always_comb begin
    mem_we_o = is_st;
    status_o = 1'b0;
    if (is_stx) begin
      // a clear in the same cycle counts as an interrupt before the store
      if (armed_i && !clear_i) mem_we_o = 1'b1;
      else                     status_o = 1'b1;
    end
  end

  assign arm_o  = is_ldx;
  assign drop_o = is_stx || clear_i;
endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      if (re_i) rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/excl_gate.sv
module excl_gate
  import excl_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          clear_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_status_o
);
  excl_op_e op;
  logic     excl_q, mem_we, status_d, arm, drop, mem_re;

  assign op     = excl_op_e'(req_op_i);
  assign mem_re = req_valid_i && ((op == OP_LD) || (op == OP_LDX));

  excl_store_gate u_gate (
    .req_valid_i (req_valid_i),
    .req_op_i    (op),
    .armed_i     (excl_q),
    .clear_i     (clear_i),
    .mem_we_o    (mem_we),
    .status_o    (status_d),
    .arm_o       (arm),
    .drop_o      (drop)
  );

  excl_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .drop_i  (drop),
    .armed_o (excl_q)
  );

  excl_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (mem_re),
    .we_i    (mem_we),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .rdata_o (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_status_o <= req_valid_i && status_d;
    end
  end
endmodule

// File: rtl/excl_gate_chk.sv
module excl_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_op_i,
  input logic       clear_i,
  input logic       excl_q,
  input logic       mem_we,
  input logic       rsp_valid_o,
  input logic       rsp_status_o
);
  logic stx, ldx, plain;
  assign stx   = req_valid_i && (req_op_i == 2'd3);
  assign ldx   = req_valid_i && (req_op_i == 2'd2);
  assign plain = req_valid_i && !req_op_i[1];

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R9
  AST_LDX_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldx && !clear_i) |=> excl_q); // R2
  AST_STX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx && excl_q && !clear_i) |=> !rsp_status_o); // R3
  AST_STX_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx && !excl_q) |=> rsp_status_o); // R4
  AST_STX_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx && (!excl_q || clear_i)) |-> !mem_we); // R7
  AST_STX_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx |=> !excl_q); // R5
  AST_CLEAR_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !excl_q); // R6
  AST_PLAIN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain && !clear_i) |=> $stable(excl_q)); // R8
endmodule

bind excl_gate excl_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .clear_i      (clear_i),
  .excl_q       (excl_q),
  .mem_we       (mem_we),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_status_o (rsp_status_o)
);

// File: tb/excl_gate_test.sv
module excl_gate_test;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          clear_i = 1'b0;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          rsp_status_o;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] got_data;
  logic          got_status;
  logic          got_valid;

  always #10 clk_i = ~clk_i;

  excl_gate #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, response visible at the following negedge
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic clr);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a; req_wdata_i = d; clear_i = clr;
    @(negedge clk_i);
    got_valid = rsp_valid_o; got_data = rsp_rdata_o; got_status = rsp_status_o;
    req_valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic idle_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    check(rsp_valid_o == 1'b0, "R1 valid low", {31'b0, rsp_valid_o}, 0);
    issue(2'd3, 4'd1, 32'h55, 1'b0);
    check(got_status == 1'b1, "R1 first stx fails", {31'b0, got_status}, 1);
    check(got_valid == 1'b1, "R9 pulse", {31'b0, got_valid}, 1);
    @(negedge clk_i);
    check(rsp_valid_o == 1'b0, "R9 single pulse", {31'b0, rsp_valid_o}, 0);
  endtask

  task automatic t_basic();
    issue(2'd1, 4'd2, 32'hA5, 1'b0);
    check(got_status == 1'b0, "R8 plain store status", {31'b0, got_status}, 0);
    issue(2'd2, 4'd2, 0, 1'b0);
    check(got_data == 32'hA5, "R2 ldx data", got_data, 32'hA5);
    issue(2'd3, 4'd2, 32'hB6, 1'b0);
    check(got_status == 1'b0, "R3 stx passes", {31'b0, got_status}, 0);
    issue(2'd0, 4'd2, 0, 1'b0);
    check(got_data == 32'hB6, "R3 written", got_data, 32'hB6);
    issue(2'd3, 4'd2, 32'hC7, 1'b0);
    check(got_status == 1'b1, "R5 second stx fails", {31'b0, got_status}, 1);
    issue(2'd0, 4'd2, 0, 1'b0);
    check(got_data == 32'hB6, "R4 no write", got_data, 32'hB6);
  endtask

  task automatic t_plain_keeps();
    issue(2'd2, 4'd4, 0, 1'b0);
    issue(2'd1, 4'd5, 32'h11, 1'b0);
    issue(2'd0, 4'd5, 0, 1'b0);
    check(got_data == 32'h11, "R8 plain load data", got_data, 32'h11);
    issue(2'd3, 4'd4, 32'h22, 1'b0);
    check(got_status == 1'b0, "R8 flag kept armed", {31'b0, got_status}, 0);
  endtask

  task automatic t_clear();
    issue(2'd2, 4'd6, 0, 1'b0);
    idle_clear();
    issue(2'd3, 4'd6, 32'h33, 1'b0);
    check(got_status == 1'b1, "R6 clear disarms", {31'b0, got_status}, 1);
    issue(2'd2, 4'd6, 0, 1'b1);
    issue(2'd3, 4'd6, 32'h44, 1'b0);
    check(got_status == 1'b1, "R6 clear beats ldx", {31'b0, got_status}, 1);
    issue(2'd2, 4'd6, 0, 1'b0);
    issue(2'd3, 4'd6, 32'h55, 1'b1);
    check(got_status == 1'b1, "R7 clear with stx fails", {31'b0, got_status}, 1);
    issue(2'd0, 4'd6, 0, 1'b0);
    check(got_data == 32'h0, "R7 no write", got_data, 0);
  endtask

  task automatic t_retry();
    int succ = 0;
    int fails = 0;
    int attempt = 0;
    logic [DW-1:0] v;
    while (succ < 20 && attempt < 200) begin
      issue(2'd2, 4'd9, 0, 1'b0);
      v = got_data;
      if (attempt % 3 == 1) idle_clear();
      issue(2'd3, 4'd9, v + 1, attempt % 5 == 2);
      if (got_status == 1'b0) succ++; else fails++;
      attempt++;
    end
    issue(2'd0, 4'd9, 0, 1'b0);
    check(got_data == DW'(succ), "R10 counter equals successes", got_data, DW'(succ));
    check(fails > 0, "R10 clears caused retries", DW'(fails), 1);
  endtask

  initial begin
    got_data = '0; got_status = 1'b0; got_valid = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_plain_keeps();
    t_clear();
    t_retry();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule